// File: doc/BRIEF.md
# Input Level Detector with Dwell Hysteresis

This block watches sampled input words on two ports, A and B, and drives a pair of level-indicator outputs for each port. A port's indicator turns active as soon as a sample's ten most significant bits reach a programmed upper threshold. It turns inactive again only after the input has stayed at or below a separate, lower threshold for a programmed number of consecutive samples. Any sample that climbs back above the lower threshold during that wait restarts the count. Two thresholds plus a time qualifier give hysteresis in both amplitude and time. A gain-control loop can act on the indicator without chattering.

Each port has its own lower threshold, upper threshold, dwell count and a small control word. The control word selects the indicator polarity and one of two modes. In single-channel mode, output 0 of the pair carries the indicator and output 1 carries its complement. In interleaved mode, successive samples belong alternately to two time-multiplexed channels, and each channel keeps its own dwell state and drives its own output of the pair. Configuration is written through an address register followed by a data write. Both writes are accepted only while an access-enable input is high.

The sample inputs use valid/ready handshakes. Ready is held high at all times, so the block never applies back-pressure. A sample is consumed in every cycle where valid is high, and the data lines are ignored when valid is low. Dwell counts therefore count accepted samples.

Top module: `ld_top`

## Requirements
- R1: While cfg_en is high, a cycle with cfg_we high and cfg_sel low loads cfg_wdata[2:0] into the address register. A cycle with cfg_we high and cfg_sel high writes cfg_wdata into the addressed register. Addresses 0,1,2,3 select port A's lower threshold (10 bits), upper threshold (10 bits), dwell count (20 bits) and control word. Addresses 4 to 7 select the same four registers for port B.
- R2: While cfg_en is low, cfg_we has no effect on the address register or on any configuration register.
- R3: Comparisons use the ten most significant bits of a sample. A valid sample whose top bits are greater than or equal to the upper threshold makes the indicator of its channel active from the following cycle onward and loads that channel's dwell counter with the dwell value.
- R4: While a channel is active, each valid sample at or below the lower threshold decrements its counter. The sample that brings the counter to zero makes the indicator inactive from the following cycle onward, so release takes exactly dwell-value consecutive low samples.
- R5: While a channel is active, a valid sample above the lower threshold but below the upper threshold reloads the counter with the dwell value.
- R6: A dwell value of zero disables the port. Its channels go inactive within one cycle of the write, and samples cannot activate them.
- R7: Control bit 4 sets polarity. When it is 0, an active channel drives its output high. When it is 1, an active channel drives its output low.
- R8: Control bit 3 at 0 selects single-channel mode. Every sample goes to channel 0, output bit 0 carries the indicator and output bit 1 carries its complement.
- R9: Control bit 3 at 1 selects interleaved mode. The first valid sample after the mode is entered goes to channel 0, and later samples alternate between channel 0 and channel 1. Each channel has independent dwell state and drives output bit of the same index.
- R10: a_ready and b_ready are always high. A cycle with valid low changes no detector state.
- R11: After reset, all configuration registers and counters are zero and all channels are inactive, so each indicator pair reads 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Access enable for configuration writes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0: write address register, 1: write addressed data register |
| cfg_wdata | input | 20 | Configuration write data |
| a_valid | input | 1 | Port A sample valid |
| a_data | input | 16 | Port A sample word |
| a_ready | output | 1 | Port A ready (always high) |
| b_valid | input | 1 | Port B sample valid |
| b_data | input | 16 | Port B sample word |
| b_ready | output | 1 | Port B ready (always high) |
| ind_a | output | 2 | Port A indicator pair |
| ind_b | output | 2 | Port B indicator pair |

## Verification
The bench probes the boundaries of both thresholds with samples exactly equal to them. A design that used strict comparisons would then miss activation or start the dwell count one level too late. It counts release to the exact sample and inserts an in-between sample mid-count, which catches an off-by-one dwell counter and a counter that pauses instead of reloading. It writes a zero dwell while a channel is active and writes registers with access disabled. Either mistake would show up as an indicator that stays lit or reacts to a threshold it should never have received. Interleaved traffic with staggered activations exposes channels that share state or a phase that starts on the wrong channel.

// File: rtl/ld_pkg.sv
package ld_pkg;
  parameter int THR_W      = 10;
  parameter int DWELL_W    = 20;
  parameter int NPORTS     = 2;
  parameter int NCH        = 2;
  parameter int REGS_PER_P = 4;
  localparam int ADDR_W    = $clog2(NPORTS * REGS_PER_P);
  localparam int POL_BIT   = 4;
  localparam int MODE_BIT  = 3;

  typedef struct packed {
    logic [THR_W-1:0]   lo_thr;
    logic [THR_W-1:0]   hi_thr;
    logic [DWELL_W-1:0] dwell;
    logic               inv_pol;
    logic               ilv;
  } ld_port_cfg_t;
endpackage

// File: rtl/ld_cfg_regs.sv
module ld_cfg_regs
  import ld_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_en,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [DWELL_W-1:0] wr_data,
  output ld_port_cfg_t       cfg [NPORTS]
);
  logic [ADDR_W-1:0] addr_q;
  ld_port_cfg_t      cfg_q [NPORTS];
  logic              wr_ok;

  assign wr_ok = acc_en && wr_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (wr_ok && !wr_sel) begin
      addr_q <= wr_data[ADDR_W-1:0];
    end
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic sel_port;
    assign sel_port = (int'(addr_q[ADDR_W-1:2]) == p);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cfg_q[p] <= '0;
      end else if (wr_ok && wr_sel && sel_port) begin
        case (addr_q[1:0])
          2'd0: cfg_q[p].lo_thr <= wr_data[THR_W-1:0];
          2'd1: cfg_q[p].hi_thr <= wr_data[THR_W-1:0];
          2'd2: cfg_q[p].dwell  <= wr_data;
          default: begin
            cfg_q[p].inv_pol <= wr_data[POL_BIT];
            cfg_q[p].ilv     <= wr_data[MODE_BIT];
          end
        endcase
      end
    end
    assign cfg[p] = cfg_q[p];
  end
endmodule

// File: rtl/ld_channel.sv
module ld_channel
  import ld_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smp_en,
  input  logic [THR_W-1:0]   level,
  input  logic [THR_W-1:0]   lo_thr,
  input  logic [THR_W-1:0]   hi_thr,
  input  logic [DWELL_W-1:0] dwell,
  output logic               active
);
  logic               act_q;
  logic [DWELL_W-1:0] cnt_q;
  logic               hit_hi;
  logic               at_lo;

  assign hit_hi = (level >= hi_thr);
  assign at_lo  = (level <= lo_thr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (dwell == '0) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (smp_en) begin
      if (hit_hi) begin
        act_q <= 1'b1;
        cnt_q <= dwell;
      end else if (act_q) begin
        if (at_lo) begin
          if (cnt_q <= DWELL_W'(1)) begin
            act_q <= 1'b0;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q - DWELL_W'(1);
          end
        end else begin
          cnt_q <= dwell;
        end
      end
    end
  end

  assign active = act_q;
endmodule

// File: rtl/ld_port.sv
module ld_port
  import ld_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  input  logic [THR_W-1:0] s_level,
  input  ld_port_cfg_t     cfg,
  output logic [NCH-1:0]   ind
);
  logic           phase_q;
  logic [NCH-1:0] ch_en;
  logic [NCH-1:0] ch_act;

  always_ff @(posedge clk) begin
    if (!rst_n || !cfg.ilv) begin
      phase_q <= 1'b0;
    end else if (s_valid) begin
      phase_q <= ~phase_q;
    end
  end

  assign ch_en[0] = s_valid && (!cfg.ilv || !phase_q);
  assign ch_en[1] = s_valid && cfg.ilv && phase_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ld_channel u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .smp_en (ch_en[c]),
      .level  (s_level),
      .lo_thr (cfg.lo_thr),
      .hi_thr (cfg.hi_thr),
      .dwell  (cfg.dwell),
      .active (ch_act[c])
    );
  end

  assign ind[0] = cfg.inv_pol ^ ch_act[0];
  assign ind[1] = cfg.ilv ? (cfg.inv_pol ^ ch_act[1]) : ~(cfg.inv_pol ^ ch_act[0]);
endmodule

// File: rtl/ld_top.sv
module ld_top
  import ld_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_en,
  input  logic               cfg_we,
  input  logic               cfg_sel,
  input  logic [DWELL_W-1:0] cfg_wdata,
  input  logic               a_valid,
  input  logic [DATA_W-1:0]  a_data,
  output logic               a_ready,
  input  logic               b_valid,
  input  logic [DATA_W-1:0]  b_data,
  output logic               b_ready,
  output logic [NCH-1:0]     ind_a,
  output logic [NCH-1:0]     ind_b
);
  localparam int LSB_W = DATA_W - THR_W;

  ld_port_cfg_t     cfg_q [NPORTS];
  logic [NPORTS-1:0] p_valid;
  logic [THR_W-1:0]  p_level [NPORTS];
  logic [NCH-1:0]    p_ind [NPORTS];
  logic              unused_lsbs;

  assign p_valid    = {b_valid, a_valid};
  assign p_level[0] = a_data[DATA_W-1 -: THR_W];
  assign p_level[1] = b_data[DATA_W-1 -: THR_W];
  assign unused_lsbs = ^{a_data[LSB_W-1:0], b_data[LSB_W-1:0]};

  ld_cfg_regs u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc_en  (cfg_en),
    .wr_en   (cfg_we),
    .wr_sel  (cfg_sel),
    .wr_data (cfg_wdata),
    .cfg     (cfg_q)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    ld_port u_port (
      .clk     (clk),
      .rst_n   (rst_n),
      .s_valid (p_valid[p]),
      .s_level (p_level[p]),
      .cfg     (cfg_q[p]),
      .ind     (p_ind[p])
    );
  end

  assign a_ready = 1'b1;
  assign b_ready = 1'b1;
  assign ind_a   = p_ind[0];
  assign ind_b   = p_ind[1];
endmodule

// File: rtl/ld_checker.sv
module ld_checker
  import ld_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_en,
  input logic             cfg_we,
  input logic             a_valid,
  input logic             a_ready,
  input logic             b_ready,
  input logic [THR_W-1:0] a_level,
  input logic [NCH-1:0]   ind_a,
  input ld_port_cfg_t     cfg_a
);
  logic wr;
  assign wr = cfg_en && cfg_we;

  assert_ready_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    a_ready && b_ready);

  assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !a_valid && !wr && !$past(wr) |=> $stable(ind_a));

  assert_single_complement_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_a.ilv |-> (ind_a[1] == ~ind_a[0]));

  assert_upper_activates_R3: assert property (@(posedge clk) disable iff (!rst_n)
    a_valid && !wr && !cfg_a.ilv && (cfg_a.dwell != '0) && (a_level >= cfg_a.hi_thr)
    |=> (ind_a[0] == ~cfg_a.inv_pol));

  assert_zero_dwell_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_a.dwell == '0) && !wr |=> (ind_a[0] == cfg_a.inv_pol));
endmodule

bind ld_top ld_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cfg_en  (cfg_en),
  .cfg_we  (cfg_we),
  .a_valid (a_valid),
  .a_ready (a_ready),
  .b_ready (b_ready),
  .a_level (p_level[0]),
  .ind_a   (ind_a),
  .cfg_a   (cfg_q[0])
);

// File: tb/ld_top_tb.sv
module ld_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_en = 1'b0, cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [19:0] cfg_wdata = '0;
  logic        a_valid = 1'b0, b_valid = 1'b0;
  logic [15:0] a_data = '0, b_data = '0;
  logic        a_ready, b_ready;
  logic [1:0]  ind_a, ind_b;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ld_top u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .a_valid(a_valid), .a_data(a_data), .a_ready(a_ready),
    .b_valid(b_valid), .b_data(b_data), .b_ready(b_ready), .ind_a(ind_a), .ind_b(ind_b)
  );

  // Port A single mode: lower 100, upper 500, dwell 3, active-high
  localparam int NV = 16;
  localparam int VEC_X [NV] = '{200, 500, 300, 100, 50, 300, 100, 100,
                                100, 100, 499, 600, 101, 99, 99, 99};
  localparam bit VEC_E [NV] = '{0, 1, 1, 1, 1, 1, 1, 1,
                                0, 0, 0, 1, 1, 1, 1, 0};

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic sel, input logic [19:0] val, input logic en);
    @(negedge clk);
    cfg_en = en; cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_en = 1'b0; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
  endtask

  task automatic wr_reg(input int addr, input int val);
    cfg_write(1'b0, 20'(addr), 1'b1);
    cfg_write(1'b1, 20'(val), 1'b1);
  endtask

  task automatic smp_a(input int x);
    @(negedge clk);
    a_valid = 1'b1; a_data = 16'(x << 6);
    @(negedge clk);
    a_valid = 1'b0;
  endtask

  task automatic smp_b(input int x);
    @(negedge clk);
    b_valid = 1'b1; b_data = 16'(x << 6);
    @(negedge clk);
    b_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state, R10 ready
    check("R11 reset ind_a", ind_a, 2'b10);
    check("R11 reset ind_b", ind_b, 2'b10);
    check("R10 ready", {a_ready, b_ready}, 2'b11);

    // R1 configure port A
    wr_reg(0, 100); wr_reg(1, 500); wr_reg(2, 3); wr_reg(3, 0);

    // R3 R4 R5 R8 vector walk
    for (int i = 0; i < NV; i++) begin
      smp_a(VEC_X[i]);
      check($sformatf("R3/R4/R5/R8 vec %0d", i), ind_a, {~VEC_E[i], VEC_E[i]});
    end

    // R10 samples with valid low are ignored
    @(negedge clk); a_data = 16'(900 << 6);
    repeat (3) @(negedge clk);
    check("R10 valid low ignored", ind_a, 2'b10);

    // R2 writes with access disabled: try upper A = 50
    cfg_write(1'b0, 20'd1, 1'b0);
    cfg_write(1'b1, 20'd50, 1'b0);
    smp_a(300);
    check("R2 disabled write ignored", ind_a, 2'b10);
    smp_a(500);
    check("R1 upper still 500", ind_a, 2'b01);

    // R7 polarity inverted while active
    wr_reg(3, 'h10);
    check("R7 inverted active", ind_a, 2'b10);
    smp_a(100); smp_a(100);
    check("R4 not yet released", ind_a, 2'b10);
    smp_a(100);
    check("R7 inverted inactive", ind_a, 2'b01);

    // R6 dwell zero on active channel
    smp_a(600);
    check("R7 inverted reactivated", ind_a, 2'b10);
    wr_reg(2, 0);
    @(negedge clk);
    check("R6 zero dwell releases", ind_a, 2'b01);
    smp_a(900);
    check("R6 zero dwell blocks", ind_a, 2'b01);

    // R6 port B disabled after reset default dwell 0
    wr_reg(4, 100); wr_reg(5, 500);
    smp_b(900);
    check("R6 port B disabled", ind_b, 2'b10);

    // R9 interleaved port B, dwell 2
    wr_reg(6, 2); wr_reg(7, 'h08);
    check("R9 interleaved idle", ind_b, 2'b00);
    smp_b(600); check("R9 ch0 on", ind_b, 2'b01);
    smp_b(50);  check("R9 ch1 low", ind_b, 2'b01);
    smp_b(50);  check("R9 ch0 count", ind_b, 2'b01);
    smp_b(600); check("R9 ch1 on", ind_b, 2'b11);
    smp_b(50);  check("R9 ch0 off", ind_b, 2'b10);
    smp_b(50);  check("R9 ch1 count", ind_b, 2'b10);
    smp_b(50);  check("R9 ch0 stays", ind_b, 2'b10);
    smp_b(50);  check("R9 ch1 off", ind_b, 2'b00);
    check("R9 port A untouched", ind_a, 2'b01);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule